// File: doc/BRIEF.md
# Shared-Bus Register Port with Read-Back

This block is the control port of a data converter. A single 12-bit output word normally carries the latest conversion result. The same pins also serve register traffic. A host moves the port through its phases with a low-going strobe and two phase-select pins. `rd_nwr` chooses between host-driven and device-driven. `dat_nadr` chooses between an address phase and a data phase. The block acts on the rising edge of the strobe once that edge has passed a two-stage synchronizer. At that moment it samples the phase pins and the host byte (bus bits [11:4]).

To write a register, the host first sends an address phase and then a data phase. To read one back, the host sends an address phase with address bit 4 set, followed by a read strobe. The byte stored at that address, with bit 4 cleared, then appears on bus bits [11:4]. It stays there until the next strobe falling edge is seen, after which the bus returns to conversion data.

Two registers drive the power decode. One holds a master enable, a select-mode flag and a clamp-DAC override. The other holds a per-block select mask. From these the block produces eight block enables. Output drive is controlled combinationally from the pins: an active-low output enable, and the read/write pin.

The conversion word arrives as a plain held bus with a one-cycle `conv_valid` load pulse. It has no back-pressure. Each new word simply replaces the previous one.

Top module: `pario_regport`

## Requirements
- R1: A strobe rising edge is acted on at the third rising clock edge after it, counting the edge that first samples the high level. An address phase is `rd_nwr`=0 and `dat_nadr`=0. It latches `host_byte[5:0]` (bus bits [9:4]) as the current address.
- R2: A read strobe is `rd_nwr`=1 and `dat_nadr`=1. It loads the register at the current address with bit 4 forced to 0. From the acting edge onward, `bus_out[11:4]` carries that byte and `bus_out[3:0]` is 0.
- R3: Read-back data stays on `bus_out` until a strobe falling edge has been seen. That edge is taken at the third rising clock edge after the pin falls. From then on, `bus_out` carries the held conversion word.
- R4: While `out_en_n` is 1, `bus_oe` is 0, whatever the other pins are.
- R5: While `rd_nwr` is 0, `bus_oe` is 0. When `out_en_n` is 0 and `rd_nwr` is 1, `bus_oe` is 1.
- R6: The control register is at address 0x01: bit 0 is the master enable, bit 1 is select mode, and bit 2 is the clamp-DAC override. With select mode 0, all eight `blk_en` bits follow the master enable (0x00 or 0xFF), except as R8 says.
- R7: With select mode 1, `blk_en` equals the mask register at address 0x02, except as R8 says.
- R8: When the clamp-DAC override bit is 1, `blk_en[7]` (the clamp DAC) is 0, whatever the master enable or mask.
- R9: A write strobe is `rd_nwr`=0 and `dat_nadr`=1. It stores `host_byte` at the current address. No other event changes a register, and every register keeps its value while blocks are powered down. All registers reset to 0.
- R10: A `conv_valid` pulse stores `conv_data`. The stored word appears on `bus_out` from the next clock edge onward, whenever read-back data is not being shown.
- R11: A strobe with `rd_nwr`=1 and `dat_nadr`=0 changes neither the registers nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Asynchronous active-low strobe from the host |
| rd_nwr | input | 1 | 1 = device drives the bus, 0 = host drives the bus |
| dat_nadr | input | 1 | 1 = data phase, 0 = address phase |
| out_en_n | input | 1 | Active-low output drive enable |
| host_byte | input | 8 | Host-driven bus bits [11:4] |
| conv_valid | input | 1 | Load pulse for a new conversion word |
| conv_data | input | 12 | Conversion result |
| bus_out | output | 12 | Value the device drives on the bus |
| bus_oe | output | 1 | 1 = device drives the bus, 0 = high impedance |
| blk_en | output | 8 | Per-block power enables; bit 7 is the clamp DAC |

## Verification
Strobe-driven results take effect at the third rising clock edge after the strobe pin changes. That applies to address latching, register writes, loading read-back data, and releasing read-back when a falling edge is seen. The block enables follow the registers in the same cycle as a write. A conversion word shows on the bus one edge after its `conv_valid` pulse. `bus_oe` follows the pins with no delay.

The bench reference model advances strobe history in its own delay queue of pin samples. It compares all outputs at every falling clock edge, so each result is checked in the exact cycle it is due. Directed checks are taken only after the strobe pins have been held steady for several cycles.

// File: rtl/pario_pkg.sv
package pario_pkg;
  // host-visible widths
  localparam int BUS_W   = 12;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int NBLK    = 8;
  localparam int NIB_W   = BUS_W - DATA_W;
  localparam int DEPTH   = 1 << ADDR_W;

  // address bit that separates the read-request alias from the register
  localparam int ALIAS_BIT = 4;

  // register map
  localparam logic [ADDR_W-1:0] CTL_ADDR  = 6'h01;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 6'h02;

  // control register bits
  localparam int CTL_MASTER = 0;
  localparam int CTL_SELECT = 1;
  localparam int CTL_CLAMPX = 2;
  localparam int CTL_W      = 3;

  // block index of the clamp DAC
  localparam int CLAMP_BLK = 7;

  // strobe command from {rd_nwr, dat_nadr}
  typedef enum logic [1:0] {
    CMD_ADDR  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_NOP   = 2'b10,
    CMD_READ  = 2'b11
  } stb_cmd_t;
endpackage

// File: rtl/pario_stb_sync.sv
// Synchronizes the asynchronous strobe and yields single-cycle edge pulses.
module pario_stb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // idle level is high, so reset to high avoids a spurious edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o =  chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] &  last_q;
endmodule

// File: rtl/pario_regfile.sv
// Register storage with one write port and one combinational read port.
module pario_regfile
  import pario_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int ND = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [CTL_W-1:0] ctl_o,
  output logic [DW-1:0]    mask_o,
  output logic [ND*DW-1:0] regs_flat
);
  logic [DW-1:0] mem [ND];

  genvar e;
  generate
    for (e = 0; e < ND; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_addr == AW'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem[e] <= '0;
        else if (hit) mem[e] <= wr_data;
      end
      assign regs_flat[e*DW +: DW] = mem[e];
    end
  endgenerate

  assign rd_data = mem[rd_addr];
  assign ctl_o   = mem[CTL_ADDR][CTL_W-1:0];
  assign mask_o  = mem[MASK_ADDR];
endmodule

// File: rtl/pario_pwr_decode.sv
// Turns the control and mask registers into per-block enables.
module pario_pwr_decode
  import pario_pkg::*;
#(
  parameter int NB   = NBLK,
  parameter int CLMP = CLAMP_BLK
) (
  input  logic [CTL_W-1:0] ctl_i,
  input  logic [NB-1:0]    mask_i,
  output logic [NB-1:0]    blk_en
);
  logic master, select, clampx;

  assign master = ctl_i[CTL_MASTER];
  assign select = ctl_i[CTL_SELECT];
  assign clampx = ctl_i[CTL_CLAMPX];

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_blk
      logic base;
      assign base = select ? mask_i[b] : master;
      if (b == CLMP) begin : g_clamp
        assign blk_en[b] = base & ~clampx;
      end else begin : g_plain
        assign blk_en[b] = base;
      end
    end
  endgenerate
endmodule

// File: rtl/pario_bus_mux.sv
// Holds the conversion word and the read-back byte and picks what goes out.
module pario_bus_mux
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [BUS_W-1:0]  conv_data,
  input  logic              rb_load,
  input  logic              rb_clear,
  input  logic [DATA_W-1:0] rb_value,
  input  logic              out_en_n,
  input  logic              rd_nwr,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              rb_show
);
  logic [BUS_W-1:0]  conv_q;
  logic [DATA_W-1:0] rb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          conv_q <= '0;
    else if (conv_valid) conv_q <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_show <= 1'b0;
      rb_q    <= '0;
    end else if (rb_clear) begin
      rb_show <= 1'b0;
    end else if (rb_load) begin
      rb_show <= 1'b1;
      rb_q    <= rb_value;
    end
  end

  assign bus_out = rb_show ? {rb_q, {NIB_W{1'b0}}} : conv_q;
  // drive only when output enabled and the host is not driving
  assign bus_oe  = ~out_en_n & rd_nwr;
endmodule

// File: rtl/pario_regport.sv
module pario_regport
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              rd_nwr,
  input  logic              dat_nadr,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] host_byte,
  input  logic              conv_valid,
  input  logic [BUS_W-1:0]  conv_data,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [NBLK-1:0]   blk_en
);
  logic                    stb_rise, stb_fall;
  stb_cmd_t                cmd;
  logic [ADDR_W-1:0]       addr_q;
  logic [ADDR_W-1:0]       rd_addr;
  logic                    wr_en;
  logic                    rb_load;
  logic                    rb_show;
  logic [DATA_W-1:0]       rd_data;
  logic [CTL_W-1:0]        ctl_q;
  logic [DATA_W-1:0]       mask_q;
  logic [DEPTH*DATA_W-1:0] regs_flat;

  pario_stb_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .rise_o   (stb_rise),
    .fall_o   (stb_fall)
  );

  assign cmd = stb_cmd_t'({rd_nwr, dat_nadr});

  // address phase latches bus bits [9:4]
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          addr_q <= '0;
    else if (stb_rise && cmd == CMD_ADDR) addr_q <= host_byte[ADDR_W-1:0];
  end

  assign wr_en   = stb_rise && (cmd == CMD_WRITE);
  assign rb_load = stb_rise && (cmd == CMD_READ);

  // read request uses the address with the alias bit cleared
  always_comb begin
    rd_addr            = addr_q;
    rd_addr[ALIAS_BIT] = 1'b0;
  end

  pario_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (addr_q),
    .wr_data   (host_byte),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ctl_o     (ctl_q),
    .mask_o    (mask_q),
    .regs_flat (regs_flat)
  );

  pario_pwr_decode u_pwr (
    .ctl_i  (ctl_q),
    .mask_i (mask_q),
    .blk_en (blk_en)
  );

  pario_bus_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .rb_load    (rb_load),
    .rb_clear   (stb_fall),
    .rb_value   (rd_data),
    .out_en_n   (out_en_n),
    .rd_nwr     (rd_nwr),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .rb_show    (rb_show)
  );
endmodule

// File: rtl/pario_regport_chk.sv
module pario_regport_chk
  import pario_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    out_en_n,
  input logic                    rd_nwr,
  input logic                    bus_oe,
  input logic [BUS_W-1:0]        bus_out,
  input logic [NBLK-1:0]         blk_en,
  input logic [CTL_W-1:0]        ctl_q,
  input logic [DATA_W-1:0]       mask_q,
  input logic                    wr_en,
  input logic [DEPTH*DATA_W-1:0] regs_flat,
  input logic                    rb_show,
  input logic                    stb_fall
);
  assert_hiz_oeb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !bus_oe);

  assert_hiz_hostdrive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_nwr |-> !bus_oe);

  assert_hold_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_show && !stb_fall) |=> (rb_show && $stable(bus_out[BUS_W-1:NIB_W])));

  assert_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_MASTER] && !ctl_q[CTL_SELECT]) |-> (blk_en == '0));

  assert_mask_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_SELECT] && !ctl_q[CTL_CLAMPX]) |-> (blk_en == mask_q));

  assert_clamp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_CLAMPX] |-> !blk_en[CLAMP_BLK]);

  assert_regs_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

bind pario_regport pario_regport_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_en_n  (out_en_n),
  .rd_nwr    (rd_nwr),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .blk_en    (blk_en),
  .ctl_q     (ctl_q),
  .mask_q    (mask_q),
  .wr_en     (wr_en),
  .regs_flat (regs_flat),
  .rb_show   (rb_show),
  .stb_fall  (stb_fall)
);

// File: tb/test_pario_regport.sv
`timescale 1ns/1ps
module test_pario_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_n = 1'b1;
  logic        rd_nwr = 1'b1;
  logic        dat_nadr = 1'b0;
  logic        out_en_n = 1'b0;
  logic [7:0]  host_byte = 8'h00;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_data = 12'h000;
  logic [11:0] bus_out;
  logic        bus_oe;
  logic [7:0]  blk_en;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pario_regport i_pario_regport (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rd_nwr(rd_nwr),
    .dat_nadr(dat_nadr), .out_en_n(out_en_n), .host_byte(host_byte),
    .conv_valid(conv_valid), .conv_data(conv_data),
    .bus_out(bus_out), .bus_oe(bus_oe), .blk_en(blk_en)
  );

  // ---------------- behavioural reference ----------------
  int   mreg [64];
  int   maddr;
  bit   mshow;
  int   mrb;
  int   mconv;
  bit   hist [$];

  function automatic int exp_bus();
    return mshow ? (mrb << 4) : mconv;
  endfunction

  function automatic int exp_blk();
    int b;
    if (mreg[1] & 2) b = mreg[2];
    else             b = (mreg[1] & 1) ? 8'hFF : 8'h00;
    if (mreg[1] & 4) b = b & 8'h7F;
    return b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      maddr = 0; mshow = 0; mrb = 0; mconv = 0;
      hist.delete();
      hist.push_back(1'b1); hist.push_back(1'b1); hist.push_back(1'b1);
    end else begin
      int n;
      bit seen_rise, seen_fall;
      hist.push_back(strobe_n);
      n = hist.size();
      // strobe level seen two edges ago versus three edges ago
      seen_rise =  hist[n-3] && !hist[n-4];
      seen_fall = !hist[n-3] &&  hist[n-4];
      if (seen_fall) mshow = 0;
      if (seen_rise) begin
        case ({rd_nwr, dat_nadr})
          2'b00: maddr = host_byte[5:0];
          2'b01: mreg[maddr] = host_byte;
          2'b11: begin mrb = mreg[maddr & 6'h2F]; mshow = 1; end
          default: ;
        endcase
      end
      if (conv_valid) mconv = conv_data;
      void'(hist.pop_front());
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 3;
      if (bus_out !== 12'(exp_bus())) begin
        failures++;
        $display("FAIL R2/R3/R10 cycle %0d bus_out actual=%h expected=%h", cycle, bus_out, exp_bus());
      end
      if (blk_en !== 8'(exp_blk())) begin
        failures++;
        $display("FAIL R6/R7/R8 cycle %0d blk_en actual=%h expected=%h", cycle, blk_en, exp_blk());
      end
      if (bus_oe !== (!out_en_n && rd_nwr)) begin
        failures++;
        $display("FAIL R4/R5 cycle %0d bus_oe actual=%b expected=%b", cycle, bus_oe, !out_en_n && rd_nwr);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit rnw, input bit dna, input logic [7:0] b);
    rd_nwr = rnw; dat_nadr = dna; host_byte = b;
    cycles(2);
    strobe_n = 1'b0;
    cycles(4);
    strobe_n = 1'b1;
    cycles(6);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
    strobe(1'b0, 1'b0, {2'b00, a});
    strobe(1'b0, 1'b1, d);
    rd_nwr = 1'b1; dat_nadr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a);
    strobe(1'b0, 1'b0, {2'b00, a | 6'h10});
    strobe(1'b1, 1'b1, 8'h00);
    dat_nadr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycle);
      finish_run();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    cycles(3);
    check("R9 reset blk_en", blk_en, 8'h00);
    check("R10 reset bus_out", bus_out, 12'h000);
    rst_n = 1'b1;
    cycles(2);
    check("R9 reset state bus_out", bus_out, 12'h000);

    // R10: conversion word on the bus one edge after the pulse
    conv_data = 12'hABC; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0; conv_data = 12'h123;
    check("R10 conversion word", bus_out, 12'hABC);

    // R4 / R5 tri-state combinations
    out_en_n = 1'b1; rd_nwr = 1'b1; #1;
    check("R4 oeb high", bus_oe, 0);
    out_en_n = 1'b0; rd_nwr = 1'b0; #1;
    check("R5 host drives", bus_oe, 0);
    rd_nwr = 1'b1; #1;
    check("R5 device drives", bus_oe, 1);

    // R6: master enable
    wr_reg(6'h01, 8'h01);
    check("R6 all on", blk_en, 8'hFF);
    wr_reg(6'h01, 8'h05);
    check("R8 clamp override", blk_en, 8'h7F);

    // R7: select mode
    wr_reg(6'h02, 8'hC3);
    wr_reg(6'h01, 8'h03);
    check("R7 mask select", blk_en, 8'hC3);
    wr_reg(6'h01, 8'h07);
    check("R8 clamp in select mode", blk_en, 8'h43);

    // R2: read clears the alias bit
    wr_reg(6'h05, 8'hA5);
    wr_reg(6'h15, 8'h3C);
    rd_reg(6'h05);
    check("R2 read alias cleared", bus_out, 12'hA50);
    check("R1 read drives bus", bus_oe, 1);

    // R3: still shown while pins idle, gone after the next strobe falls
    cycles(8);
    check("R3 read-back held", bus_out, 12'hA50);
    rd_nwr = 1'b1; dat_nadr = 1'b0; host_byte = 8'hFF;
    strobe_n = 1'b0;
    cycles(2);
    check("R3 still held before edge seen", bus_out, 12'hA50);
    cycles(1);
    check("R3 released to conversion", bus_out, 12'hABC);
    strobe_n = 1'b1;
    cycles(6);

    // R11: that no-op strobe changed neither address nor registers
    strobe(1'b1, 1'b1, 8'h00);
    dat_nadr = 1'b0;
    check("R11 address unchanged", bus_out, 12'hA50);

    // R9: power down keeps registers, port still responsive
    wr_reg(6'h01, 8'h00);
    check("R6 all off", blk_en, 8'h00);
    rd_reg(6'h02);
    check("R9 mask kept in power down", bus_out, 12'hC30);
    rd_reg(6'h15);
    check("R9 alias target readable", bus_out, 12'hA50);
    rd_reg(6'h00);
    check("R9 untouched register", bus_out, 12'h000);

    // R1: action lands on the third edge after the pin rises
    rd_nwr = 1'b0; dat_nadr = 1'b0; host_byte = 8'h12;
    cycles(2);
    strobe_n = 1'b0; cycles(4);
    strobe_n = 1'b1;
    cycles(6);
    rd_nwr = 1'b1; dat_nadr = 1'b1;
    cycles(2);
    strobe_n = 1'b0; cycles(4);
    strobe_n = 1'b1;
    cycles(2);
    check("R1 not yet acted", bus_out, 12'hABC);
    cycles(1);
    check("R1 acted third edge", bus_out, 12'hC30);
    cycles(4);

    finish_run();
  end
endmodule